// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block caches page-table entries for address translation. A 24-bit virtual address splits into an 11-bit page number and a 13-bit byte offset. The page number is compared against every stored entry at once. On a hit, the block returns a 32-bit physical address: the cached 19-bit frame number placed above the unchanged offset. It also returns the entry's dirty, referenced and writable bits. When no entry matches, a miss fault is raised and nothing is translated. Software then walks its own tables and loads the mapping through the refill port.

Each entry also carries the process identifier that was current when it was loaded. With tagging enabled (the default), a hit also needs that tag to equal the current-process register. Entries of several processes can therefore live side by side. Two flush commands serve the other context-switch policies:
- an empty command wipes every entry and rewinds the replacement pointer;
- a valid-clear command drops only the valid bits and leaves the replacement pointer where it was.

A write access that lands on a read-only entry returns a protection fault instead of an address.

Lookup is purely combinational. Refill, flush and register loads take effect at the next rising clock edge.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss fault.
- R2: A lookup whose page number and process tag match a valid entry, and that is a read or a write to a writable entry, asserts `rsp_hit`. It returns `rsp_paddr = {frame, vaddr[12:0]}` together with that entry's dirty, referenced and writable bits.
- R3: A requested lookup with no matching entry asserts only `rsp_miss`, with a zero address. Without a request, `rsp_hit`, `rsp_miss` and `rsp_prot` all stay low. Exactly one of the three is high for each request.
- R4: A write lookup (`lk_write=1`) that matches an entry whose writable bit is 0 asserts only `rsp_prot` and no address. A read of the same entry hits.
- R5: The current-process register loads `pid_in` when `pid_we` is high, and the new value is used from the next cycle on. A refill stores the current value as the entry's tag. Entries with another tag never hit.
- R6: A refill whose page number and current tag already exist overwrites that entry in place. Every other entry stays intact.
- R7: A refill into a buffer that has an invalid entry takes the lowest-indexed invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer advances by one after each such replacement and wraps after the last entry.
- R8: The valid-clear command invalidates all entries from the next cycle on and leaves the round-robin pointer unchanged.
- R9: The empty command clears all entries from the next cycle on and returns the round-robin pointer to entry 0.
- R10: A refill presented in the same cycle as either flush command is discarded.
- R11: At most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 24 | Virtual address to translate |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Miss fault: no matching entry |
| rsp_prot | output | 1 | Protection fault: write to read-only entry |
| rsp_paddr | output | 32 | Physical address, zero unless hit |
| rsp_dirty | output | 1 | Dirty bit of hit entry |
| rsp_refd | output | 1 | Referenced bit of hit entry |
| rsp_wr | output | 1 | Writable bit of hit entry |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 11 | Page number to insert |
| fill_pfn | input | 19 | Frame number to insert |
| fill_dirty | input | 1 | Dirty bit to insert |
| fill_refd | input | 1 | Referenced bit to insert |
| fill_wr | input | 1 | Writable bit to insert |
| flush_all | input | 1 | Empty every entry and rewind pointer |
| flush_valid | input | 1 | Clear every valid bit only |
| pid_we | input | 1 | Load current-process register |
| pid_in | input | 8 | New current-process value |

## Verification
The following properties are checked on every cycle:
- at most one entry matches any lookup;
- each request produces exactly one of hit, miss or protection fault, and no outcome appears while idle;
- a hit carries the offset through unchanged;
- a miss drives a zero address;
- a protection fault occurs only on writes;
- nothing hits in the cycle after either flush.

Other behaviour depends on which entry was overwritten, and only the bench scenarios can show it. These cover:
- round-robin replacement order, and the difference between the two flushes (whether the pointer survives);
- in-place overwrite of a duplicate refill;
- separation of entries by process tag;
- a refill discarded when it coincides with a flush.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int VPN_W = 11;
    localparam int PFN_W = 19;
    localparam int OFF_W = 13;
    localparam int PID_W = 8;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             dirty;
        logic             refd;
        logic             wr;
    } xl_entry_t;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_MISS = 2'd2,
        OUT_PROT = 2'd3
    } xl_outcome_e;

    function automatic logic [PA_W-1:0] join_addr(logic [PFN_W-1:0] pfn,
                                                  logic [OFF_W-1:0] off);
        return {pfn, off};
    endfunction
endpackage

// File: rtl/xlat_enc.sv
`timescale 1ns/1ps
module xlat_enc #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N      = 64,
    parameter bit TAG_EN = 1'b1
) (
    input  xl_entry_t [N-1:0] ents,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [PID_W-1:0]  key_pid,
    output logic [N-1:0]      hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (TAG_EN) begin : g_tag
            assign hit_vec[g] = ents[g].vld && (ents[g].vpn == key_vpn)
                                && (ents[g].pid == key_pid);
        end else begin : g_notag
            assign hit_vec[g] = ents[g].vld && (ents[g].vpn == key_vpn);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_all,
    input  logic          fill_go,
    input  logic [N-1:0]  dup_vec,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] vic_idx
);
    logic [IW-1:0] dup_idx, free_idx, rr_q;
    logic          dup_any, free_any, evict;
    logic [N-1:0]  free_vec;

    assign free_vec = ~valid_vec;

    xlat_enc #(.N(N), .IW(IW)) u_dup_enc (
        .vec(dup_vec), .idx(dup_idx), .any(dup_any)
    );
    xlat_enc #(.N(N), .IW(IW)) u_free_enc (
        .vec(free_vec), .idx(free_idx), .any(free_any)
    );

    always_comb begin
        if (dup_any)       vic_idx = dup_idx;
        else if (free_any) vic_idx = free_idx;
        else               vic_idx = rr_q;
        evict = fill_go && !dup_any && !free_any;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            rr_q <= '0;
        end else if (evict) begin
            if (rr_q == IW'(N - 1)) rr_q <= '0;
            else                    rr_q <= rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_all,
    input  logic              flush_valid,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  xl_entry_t         wr_ent,
    output xl_entry_t [N-1:0] ents
);
    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            ents <= '0;
        end else if (flush_valid) begin
            for (int i = 0; i < N; i++) ents[i].vld <= 1'b0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter bit TAG_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic             rsp_refd,
    output logic             rsp_wr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_dirty,
    input  logic             fill_refd,
    input  logic             fill_wr,
    input  logic             flush_all,
    input  logic             flush_valid,
    input  logic             pid_we,
    input  logic [PID_W-1:0] pid_in
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    xl_entry_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0]      valid_vec, hit_vec, dup_vec;
    logic [PID_W-1:0]        cur_pid;
    logic [VPN_W-1:0]        lk_vpn;
    logic [IW-1:0]           hit_idx, vic_idx;
    logic                    hit_any, fill_go;
    xl_entry_t               new_ent;
    xl_outcome_e             outcome;

    always_ff @(posedge clk) begin
        if (rst)         cur_pid <= '0;
        else if (pid_we) cur_pid <= pid_in;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = ents[g].vld;
    end

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    xlat_match #(.N(ENTRIES), .TAG_EN(TAG_EN)) u_lk_match (
        .ents(ents), .key_vpn(lk_vpn), .key_pid(cur_pid), .hit_vec(hit_vec)
    );
    xlat_enc #(.N(ENTRIES), .IW(IW)) u_lk_enc (
        .vec(hit_vec), .idx(hit_idx), .any(hit_any)
    );

    always_comb begin
        if (!lk_valid)                        outcome = OUT_NONE;
        else if (!hit_any)                    outcome = OUT_MISS;
        else if (lk_write && !ents[hit_idx].wr) outcome = OUT_PROT;
        else                                  outcome = OUT_HIT;
    end

    always_comb begin
        rsp_hit   = (outcome == OUT_HIT);
        rsp_miss  = (outcome == OUT_MISS);
        rsp_prot  = (outcome == OUT_PROT);
        rsp_paddr = '0;
        rsp_dirty = 1'b0;
        rsp_refd  = 1'b0;
        rsp_wr    = 1'b0;
        if (outcome == OUT_HIT) begin
            rsp_paddr = join_addr(ents[hit_idx].pfn, lk_vaddr[OFF_W-1:0]);
            rsp_dirty = ents[hit_idx].dirty;
            rsp_refd  = ents[hit_idx].refd;
            rsp_wr    = ents[hit_idx].wr;
        end
    end

    // Refill path: duplicate detection uses the same compare as lookup.
    xlat_match #(.N(ENTRIES), .TAG_EN(TAG_EN)) u_fill_match (
        .ents(ents), .key_vpn(fill_vpn), .key_pid(cur_pid), .hit_vec(dup_vec)
    );

    assign fill_go = fill_en && !flush_all && !flush_valid;

    xlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .clk(clk), .rst(rst), .flush_all(flush_all), .fill_go(fill_go),
        .dup_vec(dup_vec), .valid_vec(valid_vec), .vic_idx(vic_idx)
    );

    always_comb begin
        new_ent.vld   = 1'b1;
        new_ent.pid   = cur_pid;
        new_ent.vpn   = fill_vpn;
        new_ent.pfn   = fill_pfn;
        new_ent.dirty = fill_dirty;
        new_ent.refd  = fill_refd;
        new_ent.wr    = fill_wr;
    end

    xlat_store #(.N(ENTRIES), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .flush_all(flush_all), .flush_valid(flush_valid),
        .wr_en(fill_go), .wr_idx(vic_idx), .wr_ent(new_ent), .ents(ents)
    );
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int N = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            lk_write,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_prot,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            flush_all,
    input logic            flush_valid,
    input logic [N-1:0]    hit_vec
);
    a_r11_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(rsp_hit || rsp_miss || rsp_prot));

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> ($countones({rsp_hit, rsp_miss, rsp_prot}) == 1));

    a_r3_miss_no_addr: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0));

    a_r4_prot_on_write: assert property (@(posedge clk) disable iff (rst)
        rsp_prot |-> lk_write);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    a_r8_clear_no_hit: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> !(rsp_hit || rsp_prot));

    a_r9_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !(rsp_hit || rsp_prot));
endmodule

bind xlat_cache xlat_cache_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr), .flush_all(flush_all),
    .flush_valid(flush_valid), .hit_vec(hit_vec)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [23:0] lk_vaddr = '0;
    logic        rsp_hit, rsp_miss, rsp_prot, rsp_dirty, rsp_refd, rsp_wr;
    logic [31:0] rsp_paddr;
    logic        fill_en = 1'b0;
    logic [10:0] fill_vpn = '0;
    logic [18:0] fill_pfn = '0;
    logic        fill_dirty = 1'b0, fill_refd = 1'b0, fill_wr = 1'b0;
    logic        flush_all = 1'b0, flush_valid = 1'b0;
    logic        pid_we = 1'b0;
    logic [7:0]  pid_in = '0;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty),
        .rsp_refd(rsp_refd), .rsp_wr(rsp_wr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_dirty(fill_dirty),
        .fill_refd(fill_refd), .fill_wr(fill_wr), .flush_all(flush_all),
        .flush_valid(flush_valid), .pid_we(pid_we), .pid_in(pid_in)
    );

    function automatic int vpa(int i); return i * 3 + 1; endfunction
    function automatic int pfa(int i); return i * 1001 + 7; endfunction
    function automatic int vpb(int i); return i * 5 + 3; endfunction
    function automatic int pfb(int i); return i + 100; endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic look(int vpn, int off, bit wr);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_write = wr;
        lk_vaddr = {vpn[10:0], off[12:0]};
        #1;
    endtask

    task automatic exp_hit(string req, int vpn, int pfn);
        int off;
        off = (vpn * 97 + 5) & 13'h1fff;
        look(vpn, off, 1'b0);
        chk(req, "hit", rsp_hit, 1);
        chk(req, "paddr", rsp_paddr, (longint'(pfn) << 13) | off);
    endtask

    task automatic exp_miss(string req, int vpn);
        look(vpn, 12, 1'b0);
        chk(req, "miss", rsp_miss, 1);
        chk(req, "hit", rsp_hit, 0);
    endtask

    task automatic fill(int vpn, int pfn, bit d, bit r, bit w);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn[10:0]; fill_pfn = pfn[18:0];
        fill_dirty = d; fill_refd = r; fill_wr = w;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic set_pid(int p);
        @(negedge clk);
        pid_we = 1'b1; pid_in = p[7:0];
        @(negedge clk);
        pid_we = 1'b0;
    endtask

    task automatic pulse_flush(bit full);
        @(negedge clk);
        if (full) flush_all = 1'b1; else flush_valid = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; flush_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 / R3: empty after reset, idle quiet
        #1;
        chk("R3", "idle hit", rsp_hit, 0);
        chk("R3", "idle miss", rsp_miss, 0);
        chk("R3", "idle prot", rsp_prot, 0);
        exp_miss("R1", 0);
        exp_miss("R1", 2047);

        // R2 / R4: full sweep under process 3
        set_pid(3);
        for (int i = 0; i < 64; i++)
            fill(vpa(i), pfa(i), (i % 3) == 0, (i % 5) == 0, i[0]);
        for (int i = 0; i < 64; i++) begin
            exp_hit("R2", vpa(i), pfa(i));
            chk("R2", "dirty", rsp_dirty, (i % 3) == 0);
            chk("R2", "refd", rsp_refd, (i % 5) == 0);
            chk("R2", "wr", rsp_wr, i[0]);
            look(vpa(i), 100, 1'b1);
            chk("R4", "write hit", rsp_hit, i[0]);
            chk("R4", "write prot", rsp_prot, !i[0]);
            chk("R4", "write addr", rsp_paddr,
                i[0] ? ((longint'(pfa(i)) << 13) | 100) : 0);
        end
        for (int i = 0; i < 64; i++) exp_miss("R3", vpa(i) + 1);

        // R5: register takes effect one cycle later, tag separates
        @(negedge clk);
        pid_we = 1'b1; pid_in = 8'd4;
        lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = {11'(vpa(5)), 13'd0};
        #1;
        chk("R5", "old pid still hits", rsp_hit, 1);
        @(negedge clk);
        pid_we = 1'b0;
        #1;
        chk("R5", "new pid misses", rsp_miss, 1);
        set_pid(3);
        exp_hit("R5", vpa(5), pfa(5));

        // R6: duplicate refill overwrites in place
        fill(vpa(10), 19'h7abcd, 1'b0, 1'b0, 1'b1);
        exp_hit("R6", vpa(10), 19'h7abcd);
        for (int i = 0; i < 64; i++)
            if (i != 10) exp_hit("R6", vpa(i), pfa(i));

        // R7: round-robin replacement when full
        fill(1000, 1, 1'b0, 1'b0, 1'b1);
        exp_miss("R7", vpa(0));
        exp_hit("R7", 1000, 1);
        exp_hit("R7", vpa(1), pfa(1));
        fill(1001, 2, 1'b0, 1'b0, 1'b1);
        exp_miss("R7", vpa(1));
        exp_hit("R7", vpa(2), pfa(2));

        // R8: valid-clear keeps pointer (now at entry 2)
        pulse_flush(1'b0);
        exp_miss("R8", 1000);
        for (int i = 2; i < 64; i++) exp_miss("R8", vpa(i));
        for (int i = 0; i < 64; i++) fill(vpb(i), pfb(i), 1'b0, 1'b0, 1'b1);
        fill(1500, 9, 1'b0, 1'b0, 1'b1);
        exp_miss("R8", vpb(2));
        exp_hit("R8", vpb(0), pfb(0));
        exp_hit("R8", vpb(1), pfb(1));
        exp_hit("R8", vpb(3), pfb(3));

        // R9: empty rewinds pointer to entry 0
        pulse_flush(1'b1);
        exp_miss("R9", 1500);
        for (int i = 0; i < 64; i++) fill(vpb(i), pfb(i), 1'b0, 1'b0, 1'b1);
        fill(1500, 9, 1'b0, 1'b0, 1'b1);
        exp_miss("R9", vpb(0));
        exp_hit("R9", vpb(1), pfb(1));
        exp_hit("R9", vpb(2), pfb(2));

        // R10: refill coinciding with a flush is dropped
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 11'd1777; fill_pfn = 19'd55;
        fill_wr = 1'b1; flush_valid = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_valid = 1'b0;
        exp_miss("R10", 1777);
        fill(1777, 55, 1'b0, 1'b0, 1'b1);
        exp_hit("R10", 1777, 55);

        // R5: same page under two tags
        fill(20, 19'h111, 1'b0, 1'b0, 1'b1);
        set_pid(4);
        exp_miss("R5", 20);
        fill(20, 19'h222, 1'b0, 1'b0, 1'b1);
        exp_hit("R5", 20, 19'h222);
        set_pid(3);
        exp_hit("R5", 20, 19'h111);

        @(negedge clk);
        lk_valid = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule